// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Write Master

This block issues write transactions on a 32-bit bus whose lines are shared between addressing and data. Each transaction opens with one header cycle. In the header cycle the shared lines carry a size code and a 26-bit target address. A programmable number of internal wait cycles may follow. The block then sends one or more 32-bit data beats, and the target can stretch each beat by holding its ready line low.

A local agent hands over one request at a time through a valid/ready handshake. The request carries a size code, an address and a DMA flag. The agent presents the data for the current beat on `wr_data`. The block pulses `wr_pop` in the cycle that beat completes, and the agent then moves on to the next word. The frame, chip-select, read/write, write-enable, bus-start and DMA-acknowledge strobes are all active-high, except that `bus_rnw` is driven low for a write.

Top module: `mxbus_wr_master`

## Requirements
- R1: After a synchronous reset the block is idle: `bus_frame`, `bus_cs`, `bus_we`, `bus_bs`, `bus_dack`, `bus_ad_oe` and `wr_pop` are low, `bus_rnw` is high and `req_ready` is high.
- R2: In the cycle after a request is accepted, the header cycle runs. In that cycle `bus_ad` = {size[2:0], 3'b000, addr[25:0]} (size in bits 31:29, address in bits 25:0), `bus_bs` is high and `bus_we` is low.
- R3: `cfg_iwait` (0 to 3) is sampled when the request is accepted. Exactly that many cycles lie between the header cycle and the first data cycle. In those cycles `bus_we` and `bus_bs` are low and `bus_frame` stays high.
- R4: The number of 32-bit beats is set by the size code: 000, 001 and 010 give 1 beat, 011 gives 2 beats, and any code with bit 2 set gives 8 beats.
- R5: A data cycle repeats while `tgt_ready` is low. A beat completes in the cycle in which `tgt_ready` is high, and `wr_pop` is high exactly then.
- R6: `bus_bs` is high in the first data cycle of the transaction and in no later data cycle.
- R7: `bus_frame` and `bus_cs` are high, and `bus_rnw` is low, from the header cycle through the cycle of the final beat. All three return to their idle levels in the next cycle.
- R8: `bus_we` is high only in data cycles. During data cycles `bus_ad` equals `wr_data`.
- R9: `bus_dack` equals the accepted request's DMA flag for the whole transaction and is low when idle.
- R10: `req_ready` is high only when idle. A request presented while a transaction is running has no effect.
- R11: A reset asserted in the middle of a transaction returns the block to the idle state of R1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request taken |
| req_size | input | 3 | Size code |
| req_addr | input | 26 | Target address |
| req_dma | input | 1 | Transfer is a DMA transfer to an acknowledged device |
| cfg_iwait | input | 2 | Internal wait cycles after the header |
| wr_data | input | 32 | Data for the current beat |
| wr_pop | output | 1 | Current beat completed |
| tgt_ready | input | 1 | Target ready; low stretches a data cycle |
| bus_ad | output | 32 | Shared address/data lines |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad` |
| bus_frame | output | 1 | Transaction frame |
| bus_cs | output | 1 | Chip select |
| bus_rnw | output | 1 | Read/write, low for write |
| bus_we | output | 1 | Write enable |
| bus_bs | output | 1 | Bus-start strobe |
| bus_dack | output | 1 | DMA acknowledge |

## Verification
The hardest case to reach is an 8-beat burst combined with the largest internal wait, target stalls on several beats, and a second request pushed in while the first transaction is still running. The random stimulus draws the size code, the wait setting, the DMA flag and a per-beat stall length from a fixed seed. The bench also sometimes holds `req_valid` high with junk fields during the header cycle, and it changes `cfg_iwait` after acceptance. Directed cases cover every size code and a reset asserted in the middle of a burst.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int ADDR_W  = 26;
    localparam int DATA_W  = 32;
    localparam int SIZE_W  = 3;
    localparam int IWAIT_W = 2;
    localparam int MAX_BEATS = 8;
    localparam int BEAT_W  = $clog2(MAX_BEATS + 1);
    localparam int PAD_W   = DATA_W - SIZE_W - ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HDR   = 2'd1,
        ST_IWAIT = 2'd2,
        ST_DATA  = 2'd3
    } mx_state_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic              dma;
    } mx_req_t;

    typedef struct packed {
        logic frame;
        logic cs;
        logic rnw;
        logic we;
        logic bs;
        logic dack;
        logic oe;
    } mx_strobe_t;

    function automatic logic [BEAT_W-1:0] beats_for(input logic [SIZE_W-1:0] size);
        if (size[SIZE_W-1])
            return BEAT_W'(MAX_BEATS);
        else if (size == 3'b011)
            return BEAT_W'(2);
        else
            return BEAT_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] pack_header(input logic [SIZE_W-1:0] size,
                                                      input logic [ADDR_W-1:0] addr);
        return {size, {PAD_W{1'b0}}, addr};
    endfunction

endpackage

// File: rtl/mxbus_down_counter.sv
module mxbus_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == W'(1));
endmodule

// File: rtl/mxbus_strobe_decode.sv
module mxbus_strobe_decode
    import mxbus_pkg::*;
(
    input  mx_state_e  state,
    input  logic       first_data,
    input  logic       dma,
    output mx_strobe_t strb
);
    always_comb begin
        strb = '{frame: 1'b0, cs: 1'b0, rnw: 1'b1, we: 1'b0,
                 bs: 1'b0, dack: 1'b0, oe: 1'b0};
        if (state != ST_IDLE) begin
            strb.frame = 1'b1;
            strb.cs    = 1'b1;
            strb.rnw   = 1'b0;
            strb.dack  = dma;
            strb.oe    = 1'b1;
        end
        case (state)
            ST_HDR:  strb.bs = 1'b1;
            ST_DATA: begin
                strb.we = 1'b1;
                strb.bs = first_data;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mxbus_wr_master.sv
module mxbus_wr_master
    import mxbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_dma,
    input  logic [IWAIT_W-1:0]  cfg_iwait,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_pop,
    input  logic                tgt_ready,
    output logic [DATA_W-1:0]   bus_ad,
    output logic                bus_ad_oe,
    output logic                bus_frame,
    output logic                bus_cs,
    output logic                bus_rnw,
    output logic                bus_we,
    output logic                bus_bs,
    output logic                bus_dack
);
    mx_state_e  state_q, state_d;
    mx_req_t    req_q;
    logic       first_q;
    logic       accept;
    logic       wait_zero, wait_one, beat_zero, beat_one;
    mx_strobe_t strb;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign wr_pop    = (state_q == ST_DATA) && tgt_ready;

    // Internal wait counter, loaded at acceptance.
    mxbus_down_counter #(.W(IWAIT_W)) u_wait_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cfg_iwait),
        .dec      (state_q == ST_IWAIT),
        .is_zero  (wait_zero),
        .is_one   (wait_one)
    );

    // Remaining beat counter.
    mxbus_down_counter #(.W(BEAT_W)) u_beat_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (beats_for(req_size)),
        .dec      (wr_pop),
        .is_zero  (beat_zero),
        .is_one   (beat_one)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_HDR;
            ST_HDR:   state_d = wait_zero ? ST_DATA : ST_IWAIT;
            ST_IWAIT: if (wait_one) state_d = ST_DATA;
            ST_DATA:  if (tgt_ready && (beat_one || beat_zero)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)
                req_q <= '{size: req_size, addr: req_addr, dma: req_dma};
            first_q <= (state_d == ST_DATA) && (state_q != ST_DATA);
        end
    end

    mxbus_strobe_decode u_decode (
        .state      (state_q),
        .first_data (first_q),
        .dma        (req_q.dma),
        .strb       (strb)
    );

    always_comb begin
        case (state_q)
            ST_IDLE: bus_ad = '0;
            ST_HDR:  bus_ad = pack_header(req_q.size, req_q.addr);
            default: bus_ad = wr_data;
        endcase
    end

    assign bus_ad_oe = strb.oe;
    assign bus_frame = strb.frame;
    assign bus_cs    = strb.cs;
    assign bus_rnw   = strb.rnw;
    assign bus_we    = strb.we;
    assign bus_bs    = strb.bs;
    assign bus_dack  = strb.dack;
endmodule

// File: rtl/mxbus_checker.sv
module mxbus_checker (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic wr_pop,
    input logic tgt_ready,
    input logic bus_frame,
    input logic bus_we,
    input logic bus_bs,
    input logic bus_dack
);
    // R8: write enable only inside a frame
    p_we_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> bus_frame);

    // R5: a beat completes only with target ready during a data cycle
    p_pop_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
        wr_pop |-> (tgt_ready && bus_we));

    // R5: a stalled data cycle is followed by another data cycle
    p_stall_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !tgt_ready) |=> bus_we);

    // R10: no acceptance while a frame is open
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_frame);

    // R2: a frame opens with the bus-start strobe and no write enable
    p_frame_start_bs_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_frame) |-> (bus_bs && !bus_we));

    // R7: a frame closes only after a completed beat
    p_frame_end_pop_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_frame) |-> $past(wr_pop));

    // R9: acknowledge steady inside a frame
    p_dack_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_frame && $past(bus_frame)) |-> $stable(bus_dack));
endmodule

bind mxbus_wr_master mxbus_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .wr_pop    (wr_pop),
    .tgt_ready (tgt_ready),
    .bus_frame (bus_frame),
    .bus_we    (bus_we),
    .bus_bs    (bus_bs),
    .bus_dack  (bus_dack)
);

// File: tb/tb_mxbus_wr_master.sv
`timescale 1ns/1ps
module tb_mxbus_wr_master;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_size;
    logic [25:0] req_addr;
    logic        req_dma;
    logic [1:0]  cfg_iwait;
    logic [31:0] wr_data;
    logic        wr_pop;
    logic        tgt_ready;
    logic [31:0] bus_ad;
    logic        bus_ad_oe, bus_frame, bus_cs, bus_rnw, bus_we, bus_bs, bus_dack;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mxbus_wr_master dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_addr(req_addr), .req_dma(req_dma),
        .cfg_iwait(cfg_iwait), .wr_data(wr_data), .wr_pop(wr_pop),
        .tgt_ready(tgt_ready), .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe),
        .bus_frame(bus_frame), .bus_cs(bus_cs), .bus_rnw(bus_rnw),
        .bus_we(bus_we), .bus_bs(bus_bs), .bus_dack(bus_dack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_beats(input logic [2:0] sz);
        if (sz[2]) return 8;
        if (sz == 3'b011) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] exp_header(input logic [2:0] sz, input logic [25:0] ad);
        return {sz, 3'b000, ad};
    endfunction

    function automatic logic [31:0] beat_val(input logic [25:0] ad, input int b);
        return 32'hC3000000 ^ {ad[23:0], 8'h00} ^ 32'(b * 32'h0101_0101);
    endfunction

    task automatic chk_idle(input string req);
        chk({req, " frame"}, 32'(bus_frame), 0);
        chk({req, " cs"},    32'(bus_cs), 0);
        chk({req, " we"},    32'(bus_we), 0);
        chk({req, " bs"},    32'(bus_bs), 0);
        chk({req, " dack"},  32'(bus_dack), 0);
        chk({req, " oe"},    32'(bus_ad_oe), 0);
        chk({req, " pop"},   32'(wr_pop), 0);
        chk({req, " rnw"},   32'(bus_rnw), 1);
        chk({req, " ready"}, 32'(req_ready), 1);
    endtask

    // One complete write; poke pushes a junk request during the header cycle.
    task automatic run_txn(input logic [2:0] sz, input logic [25:0] ad, input logic dm,
                           input logic [1:0] iw, input bit poke, input int max_stall);
        int nb = exp_beats(sz);
        @(negedge clk);
        req_valid = 1; req_size = sz; req_addr = ad; req_dma = dm;
        cfg_iwait = iw; wr_data = beat_val(ad, 0); tgt_ready = 0;
        #1 chk("R10 ready when idle", 32'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = poke; req_size = ~sz; req_addr = ~ad; req_dma = ~dm;
        cfg_iwait = ~iw;  // R3: change after acceptance must not matter
        #1;
        chk("R2 header word", bus_ad, exp_header(sz, ad));
        chk("R2 header bs", 32'(bus_bs), 1);
        chk("R2 header we", 32'(bus_we), 0);
        chk("R7 header frame", 32'(bus_frame), 1);
        chk("R7 header cs", 32'(bus_cs), 1);
        chk("R7 header rnw", 32'(bus_rnw), 0);
        chk("R9 header dack", 32'(bus_dack), 32'(dm));
        chk("R10 busy not ready", 32'(req_ready), 0);
        @(posedge clk);
        for (int w = 0; w < int'(iw); w++) begin
            @(negedge clk);
            req_valid = 0;
            #1;
            chk("R3 wait we", 32'(bus_we), 0);
            chk("R3 wait bs", 32'(bus_bs), 0);
            chk("R3 wait frame", 32'(bus_frame), 1);
            chk("R9 wait dack", 32'(bus_dack), 32'(dm));
            @(posedge clk);
        end
        for (int b = 0; b < nb; b++) begin
            int stall = $urandom_range(0, max_stall);
            for (int s = 0; s <= stall; s++) begin
                @(negedge clk);
                req_valid = 0;
                wr_data = beat_val(ad, b);
                tgt_ready = (s == stall);
                #1;
                chk("R8 data we", 32'(bus_we), 1);
                chk("R8 data bus", bus_ad, beat_val(ad, b));
                chk("R6 data bs", 32'(bus_bs), 32'((b == 0) && (s == 0)));
                chk("R5 pop", 32'(wr_pop), 32'(s == stall));
                chk("R7 data frame", 32'(bus_frame), 1);
                chk("R7 data rnw", 32'(bus_rnw), 0);
                chk("R9 data dack", 32'(bus_dack), 32'(dm));
                @(posedge clk);
            end
        end
        @(negedge clk);
        tgt_ready = 0;
        #1;
        chk_idle("R4 R7 R9 R10 end of frame");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        rst = 1; req_valid = 0; req_size = 0; req_addr = 0; req_dma = 0;
        cfg_iwait = 0; wr_data = 0; tgt_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 chk_idle("R1 after reset");

        // Directed: every size code, each wait setting.
        for (int c = 0; c < 8; c++)
            run_txn(3'(c), 26'h3FF_FFFF ^ 26'(c * 26'h11111), 1'(c), 2'(c), 1'b1, 1);
        run_txn(3'b111, 26'h000_0000, 1'b1, 2'd3, 1'b1, 2);

        // Random.
        for (int i = 0; i < 60; i++)
            run_txn(3'($urandom_range(0, 7)), 26'($urandom), 1'($urandom_range(0, 1)),
                    2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 3);

        // R11: reset in the middle of a burst.
        @(negedge clk);
        req_valid = 1; req_size = 3'b100; req_addr = 26'h0ABCDEF; req_dma = 1;
        cfg_iwait = 0; tgt_ready = 1;
        @(posedge clk);
        @(negedge clk); req_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 chk("R11 mid burst we", 32'(bus_we), 1);
        rst = 1;
        @(posedge clk);
        @(negedge clk); rst = 0; tgt_ready = 0;
        #1 chk_idle("R11 after mid reset");
        @(posedge clk);
        @(negedge clk); #1 chk_idle("R11 stays idle");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule